// File: doc/BRIEF.md
# Double-Buffered PWM Timer

This block is a single-channel pulse-width modulator built around an up-counter. The counter advances only on ticks from an external prescaler. It runs from zero up to a programmed period value, then clears and starts a new cycle. A second compare value, the duty, marks the point in each cycle where the output drops. The output is held in a set/reset flop. Clearing the counter sets it, and reaching the duty value resets it. Because the flop is never toggled, a missed event cannot leave the waveform inverted.

Duty updates follow one of two policies, picked by a control bit. In the buffered policy a new duty value waits in a shadow register and becomes active only at the next counter clear. The waveform therefore never loses or gains a pulse, even when it moves between always-low and always-high. In the direct policy a write takes effect on the next clock, which can drop a falling edge in the current cycle. Two one-clock interrupt pulses report the counter clear and the duty match.

A sequencer with two named states controls the block. **IDLE** holds the counter at zero and the output low. **RUN** counts ticks. The transition **START** (IDLE to RUN) is taken when `run_en` rises. The transition **STOP** (RUN to IDLE) is taken when `run_en` falls.

Top module: `pwm_dbuf_timer`

## Requirements
- R1: After reset, `pwm_out`, `irq_period` and `irq_duty` are low, the counter is 0, the period and duty registers are 0, and the buffered policy is selected.
- R2: In RUN the count changes only on clocks where `tick` is high. The count goes from 0 up to the period value, and the tick after the period value returns it to 0, so one cycle lasts period+1 ticks.
- R3: A counter clear sets the output and a count equal to the active duty resets it, and reset wins when both fall on the same tick. The output is therefore high for counts 0 to duty-1 of each cycle.
- R4: `irq_period` pulses on the clock after a clearing tick and `irq_duty` pulses on the clock after a duty-match tick. Each pulse is one clock wide per tick.
- R5: A duty of 0 keeps the output low for the whole cycle, and a duty above the period keeps it high. In buffered mode, moving between these two extremes changes the output exactly at a cycle boundary.
- R6: Writing `wr_addr`=1 loads the duty shadow register. In buffered mode the active duty takes the shadow value only at the next counter clear.
- R7: In direct mode (control bit 0 cleared), a duty write becomes the active duty on the next clock, including in the middle of a cycle.
- R8: With `run_en` low, the block is in IDLE. The count is 0, the output goes low on the next clock, and no interrupt pulses are produced. Duty and mode writes become active at once. START begins a cycle at count 0 with the output high exactly when the duty is nonzero.
- R9: Writing bit 0 at `wr_addr`=2 selects the policy (1 = buffered, 0 = direct). While running, the new policy takes effect at the next counter clear.
- R10: Writing `wr_addr`=0 changes the period at once. If the count is already at or above the new period, the next tick clears the counter.
- R11: The output rises only at a counter clear or at START, and falls only at a duty match or at STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Count enable; low forces IDLE |
| tick | input | 1 | Prescaler clock enable, one clock wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 period, 1 duty, 2 control, 3 unused |
| wr_data | input | W | Write data (control uses bit 0) |
| pwm_out | output | 1 | PWM waveform |
| irq_period | output | 1 | Counter-clear interrupt pulse |
| irq_duty | output | 1 | Duty-match interrupt pulse |

## Verification
A wrong count or a stale active duty appears on `pwm_out` as a falling edge in the wrong tick. It can also appear as a cycle with no fall at all, visible within one period of the fault. A shadow register committed at the wrong moment shifts the duty change by one cycle. In the always-low and always-high cases it adds or removes a whole pulse, visible at the next clear. Interrupt faults show up within a clock of the tick that should have produced them. For that reason every output is compared on every clock against a model driven with the same stimulus.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
    parameter int CNT_W = 16;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef enum logic [1:0] {
        RA_PERIOD = 2'd0,
        RA_DUTY   = 2'd1,
        RA_CTRL   = 2'd2,
        RA_SPARE  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/pwm_seq_fsm.sv
module pwm_seq_fsm
    import pwm_tmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         tick,
    input  logic [W-1:0] period,
    output run_state_e   state_q,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_next,
    output logic         start_ev,
    output logic         stop_ev,
    output logic         hold,
    output logic         adv,
    output logic         wrap_ev
);
    run_state_e state_d;
    logic       wrap_hit;

    // next-state: START (IDLE->RUN), STOP (RUN->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (run_en)  state_d = ST_RUN;
            ST_RUN:  if (!run_en) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // decoded outputs of the sequencer
    always_comb begin
        wrap_hit = (cnt_q >= period);
        cnt_next = wrap_hit ? '0 : cnt_q + 1'b1;
        start_ev = 1'b0;
        stop_ev  = 1'b0;
        hold     = 1'b0;
        adv      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                start_ev = run_en;
                hold     = !run_en;
            end
            ST_RUN: begin
                stop_ev = !run_en;
                adv     = run_en && tick;
            end
            default: hold = 1'b1;
        endcase
        wrap_ev = adv && wrap_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           cnt_q <= '0;
        else if (state_q == ST_RUN && run_en) begin
            if (tick) cnt_q <= cnt_next;
        end
        else                                  cnt_q <= '0;
    end
endmodule

// File: rtl/pwm_regbank.sv
module pwm_regbank
    import pwm_tmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         hold,
    input  logic         commit,
    output logic [W-1:0] period,
    output logic [W-1:0] duty_act,
    output logic [W-1:0] duty_eff,
    output logic         mode_act
);
    logic [W-1:0] duty_buf;
    logic         mode_req;
    logic         wr_per, wr_duty, wr_ctrl;

    always_comb begin
        wr_per  = wr_en && (reg_addr_e'(wr_addr) == RA_PERIOD);
        wr_duty = wr_en && (reg_addr_e'(wr_addr) == RA_DUTY);
        wr_ctrl = wr_en && (reg_addr_e'(wr_addr) == RA_CTRL);
        duty_eff = commit ? duty_buf : duty_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period   <= '0;
            duty_buf <= '0;
            mode_req <= 1'b1;
        end else begin
            if (wr_per)  period   <= wr_data;
            if (wr_duty) duty_buf <= wr_data;
            if (wr_ctrl) mode_req <= wr_data[0];
        end
    end

    // active compare and policy: follow writes when idle, commit at boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_act <= '0;
            mode_act <= 1'b1;
        end else if (hold) begin
            duty_act <= wr_duty ? wr_data : duty_buf;
            mode_act <= wr_ctrl ? wr_data[0] : mode_req;
        end else begin
            if (commit) begin
                duty_act <= duty_buf;
                mode_act <= mode_req;
            end
            if (wr_duty && !mode_act) duty_act <= wr_data;
        end
    end
endmodule

// File: rtl/pwm_sr_out.sv
module pwm_sr_out #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_ev,
    input  logic         stop_ev,
    input  logic         adv,
    input  logic         wrap_ev,
    input  logic [W-1:0] cnt_next,
    input  logic [W-1:0] duty_eff,
    output logic         pwm_q,
    output logic         irq_p_q,
    output logic         irq_d_q
);
    logic set_ev, rst_ev;

    always_comb begin
        set_ev = wrap_ev;
        rst_ev = adv && (cnt_next == duty_eff);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_q   <= 1'b0;
            irq_p_q <= 1'b0;
            irq_d_q <= 1'b0;
        end else begin
            irq_p_q <= set_ev;
            irq_d_q <= rst_ev;
            if (start_ev)     pwm_q <= (duty_eff != '0);
            else if (stop_ev) pwm_q <= 1'b0;
            else if (rst_ev)  pwm_q <= 1'b0;
            else if (set_ev)  pwm_q <= 1'b1;
        end
    end
endmodule

// File: rtl/pwm_dbuf_timer.sv
module pwm_dbuf_timer
    import pwm_tmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    output logic         pwm_out,
    output logic         irq_period,
    output logic         irq_duty
);
    run_state_e   state_q;
    logic [W-1:0] cnt_q, cnt_next, period, duty_act, duty_eff;
    logic         start_ev, stop_ev, hold, adv, wrap_ev, commit, mode_act;

    assign commit = start_ev || wrap_ev;

    pwm_seq_fsm #(.W(W)) seq_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick), .period(period),
        .state_q(state_q), .cnt_q(cnt_q), .cnt_next(cnt_next),
        .start_ev(start_ev), .stop_ev(stop_ev), .hold(hold), .adv(adv), .wrap_ev(wrap_ev)
    );

    pwm_regbank #(.W(W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hold(hold), .commit(commit), .period(period), .duty_act(duty_act),
        .duty_eff(duty_eff), .mode_act(mode_act)
    );

    pwm_sr_out #(.W(W)) out_i (
        .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .stop_ev(stop_ev), .adv(adv),
        .wrap_ev(wrap_ev), .cnt_next(cnt_next), .duty_eff(duty_eff),
        .pwm_q(pwm_out), .irq_p_q(irq_period), .irq_d_q(irq_duty)
    );
endmodule

// File: rtl/pwm_dbuf_timer_chk.sv
module pwm_dbuf_timer_chk
    import pwm_tmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run_en,
    input logic         tick,
    input logic         pwm_out,
    input logic         irq_period,
    input logic         irq_duty,
    input run_state_e   state_q,
    input logic [W-1:0] cnt_q,
    input logic         commit,
    input logic         mode_act,
    input logic [W-1:0] duty_act
);
    assert_rise_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> (irq_period || $past(state_q) == ST_IDLE));

    assert_fall_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm_out) |-> (irq_duty || !$past(run_en)));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!pwm_out && !irq_period && !irq_duty));

    assert_irq_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_period || irq_duty) |-> $past(tick));

    assert_count_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) == ST_RUN && $past(run_en) && !$past(tick))
            |-> $stable(cnt_q));

    assert_buffered_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && run_en && mode_act && !commit) |=> $stable(duty_act));
endmodule

bind pwm_dbuf_timer pwm_dbuf_timer_chk #(.W(W)) chk_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick), .pwm_out(pwm_out),
    .irq_period(irq_period), .irq_duty(irq_duty), .state_q(state_q), .cnt_q(cnt_q),
    .commit(commit), .mode_act(mode_act), .duty_act(duty_act)
);

// File: tb/pwm_dbuf_timer_tb_top.sv
`timescale 1ns/1ps
module pwm_dbuf_timer_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run_en = 1'b0, tick = 1'b0, wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         pwm_out, irq_period, irq_duty;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // bench model state
    bit           m_run;
    int unsigned  m_cnt, m_per, m_buf, m_act;
    bit           m_mreq, m_mact, m_pwm, m_ip, m_id;

    always #2 clk = ~clk;

    pwm_dbuf_timer #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out),
        .irq_period(irq_period), .irq_duty(irq_duty)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_run = 0; m_cnt = 0; m_per = 0; m_buf = 0; m_act = 0;
        m_mreq = 1; m_mact = 1; m_pwm = 0; m_ip = 0; m_id = 0;
    endtask

    // expected state after the coming edge, from the requirements
    task automatic model_edge(bit r, bit t, bit we, int a, int unsigned d);
        bit wd = we && a == 1;
        bit old_mact = m_mact;
        bit in_hold = !m_run && !r;
        m_ip = 0; m_id = 0;
        if (!m_run) begin
            m_cnt = 0;
            if (r) begin
                m_run = 1; m_act = m_buf; m_mact = m_mreq; m_pwm = (m_buf != 0);
            end else begin
                m_pwm = 0;
                m_act = wd ? d : m_buf;
                m_mact = (we && a == 2) ? d[0] : m_mreq;
            end
        end else if (!r) begin
            m_run = 0; m_cnt = 0; m_pwm = 0;
        end else if (t) begin
            if (m_cnt >= m_per) begin
                m_cnt = 0; m_act = m_buf; m_mact = m_mreq; m_ip = 1;
                m_pwm = (m_act != 0);
                if (m_act == 0) m_id = 1;
            end else begin
                m_cnt = m_cnt + 1;
                if (m_cnt == m_act) begin m_pwm = 0; m_id = 1; end
            end
        end
        if (!in_hold && wd && !old_mact) m_act = d;
        if (we && a == 0) m_per = d;
        if (wd) m_buf = d;
        if (we && a == 2) m_mreq = d[0];
    endtask

    task automatic step(string tag, bit r, bit t, bit we, int a, int unsigned d);
        @(negedge clk);
        run_en = r; tick = t; wr_en = we; wr_addr = a[1:0]; wr_data = d[W-1:0];
        model_edge(r, t, we, a, d);
        @(posedge clk);
        #1;
        chk(tag, "pwm_out", pwm_out, m_pwm);
        chk(tag, "irq_period", irq_period, m_ip);
        chk(tag, "irq_duty", irq_duty, m_id);
    endtask

    task automatic runs(string tag, int n, int tick_div);
        for (int i = 0; i < n; i++) step(tag, 1, (i % tick_div) == 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int highs;
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "pwm_out", pwm_out, 0);
        chk("R1", "irq_period", irq_period, 0);
        chk("R1", "irq_duty", irq_duty, 0);
        rst_n = 1'b1;
        step("R1", 0, 1, 0, 0, 0);

        // R8: idle writes go straight to active compare
        step("R8", 0, 0, 1, 0, 3);
        step("R8", 0, 0, 1, 1, 2);
        step("R8", 0, 0, 1, 2, 1);
        // R3: start with period 3, duty 2, tick every clock
        highs = 0;
        for (int i = 0; i < 4; i++) begin
            step("R3", 1, 1, 0, 0, 0);
            highs += pwm_out;
        end
        chk("R3", "high ticks per cycle", highs, 2);
        runs("R3", 12, 1);
        // R4 / R2: sparse ticks
        runs("R4", 20, 2);
        runs("R2", 30, 3);
        // R5: buffered transitions to all-low and all-high
        step("R5", 1, 0, 1, 1, 0);
        runs("R5", 12, 1);
        highs = 0;
        for (int i = 0; i < 8; i++) begin step("R5", 1, 1, 0, 0, 0); highs += pwm_out; end
        chk("R5", "high samples at duty 0", highs, 0);
        step("R5", 1, 0, 1, 1, 5);
        runs("R5", 8, 1);
        highs = 0;
        for (int i = 0; i < 8; i++) begin step("R5", 1, 1, 0, 0, 0); highs += pwm_out; end
        chk("R5", "high samples at duty>period", highs, 8);
        // R6: mid-cycle write in buffered mode waits for boundary
        step("R6", 1, 1, 1, 1, 1);
        runs("R6", 10, 1);
        // R9 and R7: switch to direct mode, then mid-cycle writes
        step("R9", 1, 1, 1, 2, 0);
        runs("R9", 6, 1);
        step("R7", 1, 1, 1, 1, 3);
        runs("R7", 3, 1);
        step("R7", 1, 1, 1, 1, 0);
        runs("R7", 8, 1);
        step("R9", 1, 1, 1, 2, 1);
        step("R9", 1, 1, 1, 1, 2);
        runs("R9", 10, 1);
        // R10: lower period below current count
        step("R10", 1, 1, 1, 0, 10);
        runs("R10", 12, 1);
        step("R10", 1, 1, 1, 0, 2);
        runs("R10", 10, 1);
        // R8: stop mid-cycle then restart with duty 0
        step("R8", 0, 1, 0, 0, 0);
        step("R8", 0, 1, 1, 1, 0);
        runs("R8", 6, 1);
        // R11: constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            bit r = ($urandom % 40) != 0;
            bit t = ($urandom % 3) == 0;
            bit we = ($urandom % 8) == 0;
            int a = $urandom % 4;
            int unsigned d = (a == 0) ? $urandom % 10 : (a == 1) ? $urandom % 12 : $urandom % 2;
            step("R11", r, t, we, a, d);
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule